// File: doc/BRIEF.md
# Three-Channel Mid-Value Selector With Fault Blocking

This block picks the middle of three signed samples that come from redundant, mutually asynchronous sensor channels. The samples are never expected to match bit for bit, so no exact-match vote is taken. The median itself masks a single wild channel. A deviation screen extends this to a second fault. The screen measures each channel against the value the selector last produced. Any channel that has drifted more than a programmable epsilon from that value is blocked.

A blocked channel is not removed from the vote. Its sample is replaced by a stand-in value, so the median always sees three operands. Two stand-ins are available. Midpoint mode uses zero, the centre of the signed range. Hold mode uses the previous selector output. Blocking is sticky: a channel stays blocked until the clear input is raised. The selected value, the mask of blocked channels and the index of the channel that won the median are all registered. They change only on a sample strobe, except that a clear also resets the mask.

Top module: `midsel_guard`

## Requirements
- R1: One clock edge after `smp_valid` is seen high, `sel_out` holds the median of the three operands, where a blocked channel's operand is its stand-in. While `smp_valid` is low, `sel_out` and `sel_idx` keep their values.
- R2: On a strobe, channel i is newly blocked when |sample_i − previous `sel_out`| > `eps_limit`. The subtraction is exact over the full signed range. For example, 32767 against −32768 is a distance of 65535.
- R3: A channel whose distance from the previous output is exactly `eps_limit` is not blocked.
- R4: With `hold_mode` = 0 (midpoint mode), every blocked channel enters the median as zero.
- R5: With `hold_mode` = 1 (hold mode), every blocked channel enters the median as the previous `sel_out`.
- R6: `block_mask` bit i (bit 0 = channel 0, bit 2 = channel 2) stays set until a clear. New bits are set only on a strobe, and a channel blocked earlier is still substituted on later strobes.
- R7: `clr_block` high without a strobe empties the mask after the next clock edge and leaves `sel_out` and `sel_idx` unchanged. With a strobe in the same cycle, the old mask is dropped first. The result is then only that sample's new blocks, and only those channels are substituted.
- R8: After reset, `sel_out` = 0, `block_mask` = 0 and `sel_idx` = 0. The first strobe after reset blocks no channel, whatever the distances.
- R9: `sel_idx` names the channel whose operand equals the reported median. When several operands share the median value, the lowest channel index is reported.
- R10: With one channel clamped, a second faulty channel that stays inside epsilon but lies farther from the stand-in than the good channel does not reach the output. The good channel's value is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; the three samples are taken when high |
| ch0_smp | input | DW | Channel 0 sample, signed |
| ch1_smp | input | DW | Channel 1 sample, signed |
| ch2_smp | input | DW | Channel 2 sample, signed |
| eps_limit | input | DW | Allowed distance from the previous output, unsigned |
| hold_mode | input | 1 | 0: blocked channels read as zero; 1: blocked channels read as the previous output |
| clr_block | input | 1 | Empties the blocked-channel mask |
| sel_out | output | DW | Selected (median) value, signed |
| block_mask | output | 3 | Sticky blocked flag per channel |
| sel_idx | output | 2 | Index of the channel that supplied the median |

## Verification
The hardest states to reach are the overflow boundary of the distance test and the median ties that substitution creates. The first needs the previous output pinned at one end of the signed range and a sample at the other end. The stimulus first drives all channels to the negative extreme with the widest epsilon. It then swings one channel to the positive extreme with epsilon set one below and then equal to the full distance. Ties come from hold-mode substitution, which copies the previous output into a blocked channel next to a real sample of the same value. Here the reported index must fall to the lowest matching channel. The vector table walks these states in order, and each vector builds on the output the previous one left behind.

// File: rtl/midsel_pkg.sv
package midsel_pkg;
  localparam int CH_N  = 3;
  localparam int IDX_W = 2;

  typedef enum logic {
    SUBST_MID  = 1'b0,
    SUBST_HOLD = 1'b1
  } subst_e;
endpackage

// File: rtl/midsel_dev.sv
// Deviation screen for one channel: distance to the reference with one
// guard bit, compared strictly against the limit.
module midsel_dev #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] ref_val,
  input  logic [DW-1:0] eps,
  output logic          over
);
  localparam int XW = DW + 1;

  logic signed [XW-1:0] diff;
  logic        [XW-1:0] mag;

  always_comb begin
    diff = $signed({smp[DW-1], smp}) - $signed({ref_val[DW-1], ref_val});
    mag  = diff[XW-1] ? (~diff + {{(XW-1){1'b0}}, 1'b1}) : diff;
    over = (mag > {1'b0, eps});
  end
endmodule

// File: rtl/midsel_subst.sv
// Replaces a blocked sample by the configured stand-in value.
module midsel_subst
  import midsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] smp,
  input  logic          blocked,
  input  subst_e        mode,
  input  logic [DW-1:0] prev_out,
  output logic [DW-1:0] operand
);
  logic [DW-1:0] stand_in;

  always_comb begin
    stand_in = (mode == SUBST_HOLD) ? prev_out : '0;
    operand  = blocked ? stand_in : smp;
  end
endmodule

// File: rtl/midsel_med3.sv
// Median of three signed operands by rank counting; the lowest index wins
// among operands that share the median value.
module midsel_med3
  import midsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [CH_N-1:0][DW-1:0] vals,
  output logic [DW-1:0]           med,
  output logic [IDX_W-1:0]        med_idx
);
  logic [CH_N-1:0][1:0] n_lo;
  logic [CH_N-1:0][1:0] n_hi;
  logic [CH_N-1:0]      is_mid;

  for (genvar gi = 0; gi < CH_N; gi++) begin : g_rank
    always_comb begin
      n_lo[gi] = 2'd0;
      n_hi[gi] = 2'd0;
      for (int j = 0; j < CH_N; j++) begin
        if (j != gi) begin
          if ($signed(vals[j]) < $signed(vals[gi])) n_lo[gi] = n_lo[gi] + 2'd1;
          if ($signed(vals[j]) > $signed(vals[gi])) n_hi[gi] = n_hi[gi] + 2'd1;
        end
      end
      is_mid[gi] = (n_lo[gi] <= 2'd1) && (n_hi[gi] <= 2'd1);
    end
  end

  always_comb begin
    if (is_mid[0]) begin
      med_idx = 2'd0;
      med     = vals[0];
    end else if (is_mid[1]) begin
      med_idx = 2'd1;
      med     = vals[1];
    end else begin
      med_idx = 2'd2;
      med     = vals[2];
    end
  end
endmodule

// File: rtl/midsel_guard.sv
module midsel_guard
  import midsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] ch0_smp,
  input  logic [DW-1:0] ch1_smp,
  input  logic [DW-1:0] ch2_smp,
  input  logic [DW-1:0] eps_limit,
  input  logic          hold_mode,
  input  logic          clr_block,
  output logic [DW-1:0] sel_out,
  output logic [2:0]    block_mask,
  output logic [1:0]    sel_idx
);
  logic [CH_N-1:0][DW-1:0] smp_vec;
  logic [CH_N-1:0][DW-1:0] opnd_vec;
  logic [CH_N-1:0]         over_vec;
  logic [CH_N-1:0]         new_blk;
  logic [CH_N-1:0]         mask_base;
  logic [CH_N-1:0]         mask_eff;
  logic [CH_N-1:0]         mask_d;
  logic [CH_N-1:0]         mask_q;
  logic [DW-1:0]           out_q;
  logic [IDX_W-1:0]        idx_q;
  logic                    armed_q;
  logic                    armed_d;
  logic [DW-1:0]           med;
  logic [IDX_W-1:0]        med_idx;
  subst_e                  mode;

  assign smp_vec = {ch2_smp, ch1_smp, ch0_smp};
  assign mode    = subst_e'(hold_mode);

  for (genvar gc = 0; gc < CH_N; gc++) begin : g_chan
    midsel_dev #(.DW(DW)) u_dev (
      .smp     (smp_vec[gc]),
      .ref_val (out_q),
      .eps     (eps_limit),
      .over    (over_vec[gc])
    );

    midsel_subst #(.DW(DW)) u_subst (
      .smp      (smp_vec[gc]),
      .blocked  (mask_eff[gc]),
      .mode     (mode),
      .prev_out (out_q),
      .operand  (opnd_vec[gc])
    );
  end

  midsel_med3 #(.DW(DW)) u_med (
    .vals    (opnd_vec),
    .med     (med),
    .med_idx (med_idx)
  );

  // Next-state: the clear drops the old mask before this sample's blocks merge.
  always_comb begin
    new_blk   = armed_q ? over_vec : '0;
    mask_base = clr_block ? '0 : mask_q;
    mask_eff  = mask_base | new_blk;
    mask_d    = smp_valid ? mask_eff : mask_base;
    armed_d   = armed_q | smp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      idx_q <= '0;
    end else if (smp_valid) begin
      out_q <= med;
      idx_q <= med_idx;
    end
  end

  assign sel_out    = out_q;
  assign block_mask = mask_q;
  assign sel_idx    = idx_q;
endmodule

// File: rtl/midsel_guard_chk.sv
module midsel_guard_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          clr_block,
  input logic          hold_mode,
  input logic [DW-1:0] ch0_smp,
  input logic [DW-1:0] ch1_smp,
  input logic [DW-1:0] ch2_smp,
  input logic [DW-1:0] sel_out,
  input logic [2:0]    block_mask,
  input logic [1:0]    sel_idx
);
  logic          seen_q;
  logic [DW-1:0] cap0, cap1, cap2;
  logic [DW-1:0] cap_sel;
  logic          sel_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cap0   <= '0;
      cap1   <= '0;
      cap2   <= '0;
    end else if (smp_valid) begin
      seen_q <= 1'b1;
      cap0   <= ch0_smp;
      cap1   <= ch1_smp;
      cap2   <= ch2_smp;
    end
  end

  always_comb begin
    case (sel_idx)
      2'd0:    begin cap_sel = cap0; sel_blk = block_mask[0]; end
      2'd1:    begin cap_sel = cap1; sel_blk = block_mask[1]; end
      default: begin cap_sel = cap2; sel_blk = block_mask[2]; end
    endcase
  end

  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(sel_out) && $stable(sel_idx)));

  p_mask_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_block |=> ((block_mask & $past(block_mask)) == $past(block_mask)));

  p_mask_set_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ((block_mask & ~$past(block_mask)) == 3'b000));

  p_first_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !seen_q) |=> (block_mask == 3'b000));

  p_sel_is_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (sel_blk || (sel_out == cap_sel)));

  p_zero_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !hold_mode) |=> (!sel_blk || (sel_out == '0)));

  p_hold_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && hold_mode) |=> (!sel_blk || (sel_out == $past(sel_out))));
endmodule

bind midsel_guard midsel_guard_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .clr_block  (clr_block),
  .hold_mode  (hold_mode),
  .ch0_smp    (ch0_smp),
  .ch1_smp    (ch1_smp),
  .ch2_smp    (ch2_smp),
  .sel_out    (sel_out),
  .block_mask (block_mask),
  .sel_idx    (sel_idx)
);

// File: tb/tb_midsel_guard.sv
module tb_midsel_guard;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          smp_valid;
  logic [DW-1:0] ch0_smp, ch1_smp, ch2_smp;
  logic [DW-1:0] eps_limit;
  logic          hold_mode;
  logic          clr_block;
  logic [DW-1:0] sel_out;
  logic [2:0]    block_mask;
  logic [1:0]    sel_idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  midsel_guard #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .ch0_smp(ch0_smp), .ch1_smp(ch1_smp), .ch2_smp(ch2_smp),
    .eps_limit(eps_limit), .hold_mode(hold_mode), .clr_block(clr_block),
    .sel_out(sel_out), .block_mask(block_mask), .sel_idx(sel_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic          vld;
    logic          clr;
    logic          hold;
    logic [15:0]   eps;
    logic [15:0]   a;
    logic [15:0]   b;
    logic [15:0]   c;
    logic [15:0]   e_out;
    logic [2:0]    e_mask;
    logic [1:0]    e_idx;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 15;
  // Each row depends on the output left by the row before it.
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b0,1'b0,16'd10,   16'd100,  16'd200,  16'd150,  16'd150,  3'b000,2'd2,8'd8},  // R8 first sample
    '{1'b1,1'b0,1'b0,16'd10,   16'd155,  16'd140,  16'd160,  16'd155,  3'b000,2'd0,8'd3},  // R3 exactly eps
    '{1'b1,1'b0,1'b0,16'd10,   16'd160,  16'd170,  16'd150,  16'd150,  3'b010,2'd2,8'd2},  // R2 + R4
    '{1'b1,1'b0,1'b0,16'd10,   16'd152,  16'd151,  16'd149,  16'd149,  3'b010,2'd2,8'd6},  // R6 sticky
    '{1'b1,1'b0,1'b0,16'd1000, 16'd900,  16'd150,  16'd148,  16'd148,  3'b010,2'd2,8'd10}, // R10
    '{1'b1,1'b1,1'b0,16'd10,   16'd150,  16'd149,  16'd200,  16'd149,  3'b100,2'd1,8'd7},  // R7 clear+strobe
    '{1'b1,1'b0,1'b1,16'd10,   16'd300,  16'd150,  16'd155,  16'd149,  3'b101,2'd0,8'd5},  // R5 + R9 tie
    '{1'b0,1'b1,1'b1,16'd10,   16'd0,    16'd0,    16'd0,    16'd149,  3'b000,2'd0,8'd7},  // R7 clear only
    '{1'b1,1'b0,1'b1,16'd10,   16'd140,  16'd158,  16'd155,  16'd155,  3'b000,2'd2,8'd1},  // R1
    '{1'b1,1'b0,1'b1,16'd3,    16'd170,  16'd156,  16'd157,  16'd156,  3'b001,2'd1,8'd5},  // R5
    '{1'b1,1'b1,1'b0,16'hFFFF, 16'h8000, 16'h8000, 16'h8300, 16'h8000, 3'b000,2'd0,8'd9},  // R9 tie at min
    '{1'b1,1'b0,1'b0,16'hFFFE, 16'h7FFF, 16'h8000, 16'h8000, 16'h8000, 3'b001,2'd1,8'd2},  // R2 full range
    '{1'b1,1'b1,1'b0,16'hFFFF, 16'h7FFF, 16'h8000, 16'h8000, 16'h8000, 3'b000,2'd1,8'd3},  // R3 full range
    '{1'b1,1'b1,1'b0,16'hFFFF, 16'd5,    16'd5,    16'd5,    16'd5,    3'b000,2'd0,8'd9},  // R9 all equal
    '{1'b1,1'b0,1'b0,16'hFFFF, 16'd7,    16'd3,    16'd3,    16'd3,    3'b000,2'd1,8'd9}   // R9 pair tie
  };

  task automatic check(input string req, input logic [DW-1:0] e_out,
                       input logic [2:0] e_mask, input logic [1:0] e_idx);
    n_chk++;
    if (sel_out !== e_out || block_mask !== e_mask || sel_idx !== e_idx) begin
      n_fail++;
      $display("FAIL %s: out=%0d mask=%b idx=%0d expected out=%0d mask=%b idx=%0d",
               req, $signed(sel_out), block_mask, sel_idx,
               $signed(e_out), e_mask, e_idx);
    end
  endtask

  task automatic apply(input logic vld, input logic clr, input logic hold,
                       input logic [DW-1:0] eps, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic [DW-1:0] c);
    @(negedge clk);
    smp_valid = vld; clr_block = clr; hold_mode = hold;
    eps_limit = eps; ch0_smp = a; ch1_smp = b; ch2_smp = c;
    @(negedge clk);
    smp_valid = 1'b0; clr_block = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; clr_block = 1'b0; hold_mode = 1'b0;
    eps_limit = '0; ch0_smp = '0; ch1_smp = '0; ch2_smp = '0;
    repeat (2) @(negedge clk);
    check("R8 reset state", 16'd0, 3'b000, 2'd0);
    do_reset();
    check("R8 after reset release", 16'd0, 3'b000, 2'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].vld, VT[i].clr, VT[i].hold, VT[i].eps, VT[i].a, VT[i].b, VT[i].c);
      check($sformatf("R%0d vector %0d", VT[i].req, i), VT[i].e_out, VT[i].e_mask, VT[i].e_idx);
    end

    // R1: inputs move without a strobe, outputs must not
    @(negedge clk);
    ch0_smp = 16'd900; ch1_smp = 16'd901; ch2_smp = 16'd902;
    repeat (3) @(negedge clk);
    check("R1 no strobe hold", 16'd3, 3'b000, 2'd1);

    // R8: reset mid-run, then a first sample far from zero with eps 0
    do_reset();
    check("R8 reset mid-run", 16'd0, 3'b000, 2'd0);
    apply(1'b1, 1'b0, 1'b0, 16'd0, 16'd1000, 16'hFC18, 16'd20);
    check("R8 first sample unscreened", 16'd20, 3'b000, 2'd2);
    // R4: screening now active with eps 0; ch0/ch1 blocked to zero
    apply(1'b1, 1'b0, 1'b0, 16'd0, 16'd1000, 16'hFC18, 16'd20);
    check("R4 zero stand-in", 16'd0, 3'b011, 2'd0);
    // R6: blocked channels stay substituted even when back on value
    apply(1'b1, 1'b0, 1'b0, 16'd100, 16'd2, 16'd1, 16'd50);
    check("R6 stays blocked", 16'd0, 3'b011, 2'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule